// File: doc/BRIEF.md
# Single-Wire Byte Sequencer with Timed Strong Pullup

This block turns byte-level commands into a series of bit-slot requests for a single-wire bus master that sits below it. A command carries an operation code and a data byte. The block issues one slot per bit, least significant bit first, and collects each sampled bus level into a result byte. It then returns that byte with a one-cycle response pulse.

Operations:
- A write sends the data bits.
- A read sends all ones, so that devices can pull the bus low.
- A touch sends the data bits and returns the levels sampled in those slots.

The block also holds a one-shot strong pullup request. The request is a duration in milliseconds, loaded from a separate input. After the final bit of the next write, the block drives a strong-pullup enable for that duration, provided the pullup hardware is flagged as present. If the hardware is not present, the block waits the same time with the enable low. A write clears the request after use. A touch applies the request the same way but leaves it pending. A read neither applies nor clears it.

A prescaler counts base ticks, the same ticks the bit-slot master uses, to measure milliseconds. The block stays busy until the pullup or the wait ends.

Top module: `ow_byte_seq`

## Requirements
- R1: For write (op 2'b00) and touch (op 2'b10), slot i carries bit i of the command data, so bit 0 goes first. Eight slots are issued per command.
- R2: For read (op 2'b01, and also op 2'b11), all eight slots carry a 1. Bit i of the result is the sample returned with the acknowledge of slot i.
- R3: For touch, bit i of the result is the sample returned with slot i. For write, the result is assembled in the same way.
- R4: cmd_ready_o is high only when the block is idle, and an accepted command makes busy_o high on the next cycle. slot_req_o stays high with a stable slot_bit_o until slot_ack_i arrives. rsp_valid_o is a single-cycle pulse that marks completion.
- R5: A write that finds a nonzero request D with pu_hw_en_i high drives spu_o high from the cycle after the eighth acknowledge, for exactly D×TICKS_PER_MS base ticks. spu_o falls in the same cycle that rsp_valid_o rises.
- R6: With pu_hw_en_i low, spu_o stays low, but busy_o is held for the same D×TICKS_PER_MS ticks before rsp_valid_o.
- R7: A request of zero means no pullup: the response follows the eighth acknowledge on the next cycle. Loading zero cancels a pending request.
- R8: A write that used the request clears it, so the following write has no pullup and no wait.
- R9: A touch applies a pending request like a write does, but the request stays pending for later commands.
- R10: A read ignores a pending request and leaves it pending.
- R11: If pu_load_i coincides with the eighth acknowledge of a write, the current write uses the old duration and the newly loaded duration stays pending.
- R12: spu_o is high only while busy_o is high, and no slot is requested while spu_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Base time tick shared with the bit-slot master |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Command accepted when high with valid |
| cmd_op_i | input | 2 | 00 write, 01/11 read, 10 touch |
| cmd_data_i | input | BYTE_W | Data byte to send |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_data_o | output | BYTE_W | Assembled sampled byte |
| pu_load_i | input | 1 | Load pullup request |
| pu_ms_i | input | PU_W | Pullup duration in ms, 0 cancels |
| pu_hw_en_i | input | 1 | Strong pullup hardware present |
| slot_req_o | output | 1 | Bit-slot request, held until acknowledged |
| slot_bit_o | output | 1 | Bit value for the slot |
| slot_ack_i | input | 1 | Slot done, one cycle |
| slot_sample_i | input | 1 | Bus level sampled in the slot |
| spu_o | output | 1 | Strong pullup enable |
| busy_o | output | 1 | Command, pullup or wait in progress |

## Verification
Two events can land in the same clock edge: a new pullup duration loaded on pu_load_i, and a write consuming and clearing the request on its eighth acknowledge. The bench provokes this by pulsing pu_load_i exactly when it returns the final acknowledge of a write. It judges the outcome in two steps. First, the current write must hold for the old duration. Second, a following write must hold for the newly loaded duration rather than skipping the pullup. Random sequences also mix loads, zero cancels, reads and touches against a model of the pending request.

// File: rtl/ow_seq_pkg.sv
package ow_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SLOT = 2'd1,
    ST_HOLD = 2'd2
  } seq_state_e;

  localparam logic [1:0] OP_WRITE = 2'b00;
  localparam logic [1:0] OP_TOUCH = 2'b10;

  function automatic logic op_is_read(input logic [1:0] op);
    return op[0];
  endfunction

  function automatic logic op_is_write(input logic [1:0] op);
    return op == OP_WRITE;
  endfunction
endpackage

// File: rtl/ow_ms_prescaler.sv
module ow_ms_prescaler #(
  parameter int TICKS_PER_MS = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  output logic ms_o
);
  localparam int CW = $clog2(TICKS_PER_MS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_MS - 1);

  logic [CW-1:0] cnt_q;

  assign ms_o = en_i && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else if (tick_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/ow_byte_shift.sv
module ow_byte_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              shift_i,
  input  logic              sample_i,
  output logic              bit_o,
  output logic              last_o,
  output logic [BYTE_W-1:0] q_o
);
  localparam int IW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(BYTE_W - 1);

  logic [BYTE_W-1:0] q_q;
  logic [IW-1:0]     idx_q;

  assign bit_o  = q_q[0];
  assign last_o = idx_q == LAST_IDX;
  assign q_o    = q_q;

  // sample enters at the top and walks down; after BYTE_W shifts slot i sits in bit i
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q   <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      q_q   <= data_i;
      idx_q <= '0;
    end else if (shift_i) begin
      if (BYTE_W > 1) q_q <= {sample_i, q_q[BYTE_W-1:1]};
      else            q_q <= BYTE_W'(sample_i);
      idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/ow_pullup_ctrl.sv
module ow_pullup_ctrl #(
  parameter int PU_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [PU_W-1:0] ms_i,
  input  logic            start_i,
  input  logic            consume_i,
  input  logic            hw_en_i,
  input  logic            ms_tick_i,
  output logic            pending_o,
  output logic            active_o,
  output logic            done_o,
  output logic            spu_o
);
  logic [PU_W-1:0] req_q;
  logic [PU_W-1:0] left_q;
  logic            active_q;
  logic            spu_q;

  assign pending_o = req_q != '0;
  assign active_o  = active_q;
  assign done_o    = active_q && ms_tick_i && (left_q == PU_W'(1));
  assign spu_o     = spu_q;

  // a fresh load outranks the clear done by the consuming write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else if (load_i) req_q <= ms_i;
    else if (consume_i) req_q <= '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q   <= '0;
      active_q <= 1'b0;
      spu_q    <= 1'b0;
    end else if (start_i) begin
      left_q   <= req_q;
      active_q <= 1'b1;
      spu_q    <= hw_en_i;
    end else if (done_o) begin
      left_q   <= '0;
      active_q <= 1'b0;
      spu_q    <= 1'b0;
    end else if (active_q && ms_tick_i) begin
      left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/ow_byte_seq.sv
module ow_byte_seq
  import ow_seq_pkg::*;
#(
  parameter int BYTE_W       = 8,
  parameter int PU_W         = 16,
  parameter int TICKS_PER_MS = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [1:0]        cmd_op_i,
  input  logic [BYTE_W-1:0] cmd_data_i,
  output logic              rsp_valid_o,
  output logic [BYTE_W-1:0] rsp_data_o,
  input  logic              pu_load_i,
  input  logic [PU_W-1:0]   pu_ms_i,
  input  logic              pu_hw_en_i,
  output logic              slot_req_o,
  output logic              slot_bit_o,
  input  logic              slot_ack_i,
  input  logic              slot_sample_i,
  output logic              spu_o,
  output logic              busy_o
);
  seq_state_e state_q, state_d;
  logic [1:0] op_q;
  logic       rsp_q;

  logic accept, slot_done, last_bit, sh_bit, final_ack;
  logic pu_pending, pu_active, pu_done, pu_start, pu_consume, ms_tick;

  assign accept      = cmd_valid_i && (state_q == ST_IDLE);
  assign slot_done   = (state_q == ST_SLOT) && slot_ack_i;
  assign final_ack   = slot_done && last_bit;
  assign pu_start    = final_ack && !op_is_read(op_q) && pu_pending;
  assign pu_consume  = pu_start && op_is_write(op_q);

  assign cmd_ready_o = state_q == ST_IDLE;
  assign busy_o      = state_q != ST_IDLE;
  assign slot_req_o  = state_q == ST_SLOT;
  assign slot_bit_o  = op_is_read(op_q) ? 1'b1 : sh_bit;
  assign rsp_valid_o = rsp_q;

  ow_byte_shift #(.BYTE_W(BYTE_W)) i_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .data_i  (cmd_data_i),
    .shift_i (slot_done),
    .sample_i(slot_sample_i),
    .bit_o   (sh_bit),
    .last_o  (last_bit),
    .q_o     (rsp_data_o)
  );

  ow_ms_prescaler #(.TICKS_PER_MS(TICKS_PER_MS)) i_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (pu_active),
    .tick_i(tick_i),
    .ms_o  (ms_tick)
  );

  ow_pullup_ctrl #(.PU_W(PU_W)) i_pullup (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (pu_load_i),
    .ms_i     (pu_ms_i),
    .start_i  (pu_start),
    .consume_i(pu_consume),
    .hw_en_i  (pu_hw_en_i),
    .ms_tick_i(ms_tick),
    .pending_o(pu_pending),
    .active_o (pu_active),
    .done_o   (pu_done),
    .spu_o    (spu_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_SLOT;
      ST_SLOT: if (final_ack) state_d = pu_start ? ST_HOLD : ST_IDLE;
      ST_HOLD: if (pu_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_WRITE;
      rsp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) op_q <= cmd_op_i;
      rsp_q <= (final_ack && !pu_start) || ((state_q == ST_HOLD) && pu_done);
    end
  end
endmodule

// File: rtl/ow_byte_seq_chk.sv
module ow_byte_seq_chk #(
  parameter int BYTE_W = 8,
  parameter int PU_W   = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic              cmd_ready_o,
  input logic              rsp_valid_o,
  input logic              slot_req_o,
  input logic              slot_bit_o,
  input logic              slot_ack_i,
  input logic              spu_o,
  input logic              busy_o
);
  assert_accept_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_ready_o |=> busy_o);
  assert_ready_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_req_o |-> !cmd_ready_o);
  assert_rsp_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  assert_req_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_req_o && !slot_ack_i |=> slot_req_o && $stable(slot_bit_o));
  assert_spu_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(spu_o) |-> rsp_valid_o);
  assert_spu_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spu_o |-> busy_o);
  assert_no_slot_spu_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spu_o |-> !slot_req_o);
endmodule

bind ow_byte_seq ow_byte_seq_chk #(.BYTE_W(BYTE_W), .PU_W(PU_W)) i_chk (.*);

// File: tb/test_ow_byte_seq.sv
module test_ow_byte_seq;
  localparam int BW = 8;
  localparam int PW = 4;
  localparam int TPM = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b1;
  logic cmd_valid_i = 1'b0, cmd_ready_o;
  logic [1:0] cmd_op_i = 2'b00;
  logic [BW-1:0] cmd_data_i = '0, rsp_data_o;
  logic rsp_valid_o;
  logic pu_load_i = 1'b0, pu_hw_en_i = 1'b0;
  logic [PW-1:0] pu_ms_i = '0;
  logic slot_req_o, slot_bit_o, slot_ack_i = 1'b0, slot_sample_i = 1'b0;
  logic spu_o, busy_o;

  int errors = 0, checks = 0;
  int pend = 0;

  always #5 clk_i = ~clk_i;

  ow_byte_seq #(.BYTE_W(BW), .PU_W(PW), .TICKS_PER_MS(TPM)) i_ow_byte_seq (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_hold(input logic [1:0] op);
    if (op[0]) return 0;
    return pend * TPM;
  endfunction

  task automatic load_pu(input int v);
    @(negedge clk_i);
    pu_load_i = 1'b1; pu_ms_i = PW'(v);
    @(negedge clk_i);
    pu_load_i = 1'b0;
    pend = v;
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [BW-1:0] d, input logic [BW-1:0] dev,
                         input logic hw, input bit coin, input int coin_v, input string req);
    logic [BW-1:0] sent;
    int idx, lat, hold_cnt, spu_cnt, e_hold, e_spu, guard;
    bit ackq;
    logic [BW-1:0] e_sent;
    e_hold = exp_hold(op);
    e_spu  = hw ? e_hold : 0;
    e_sent = op[0] ? '1 : d;
    sent = '0; idx = 0; lat = 0; hold_cnt = 0; spu_cnt = 0; ackq = 0; guard = 0;
    @(negedge clk_i);
    pu_hw_en_i = hw;
    cmd_op_i = op; cmd_data_i = d; cmd_valid_i = 1'b1;
    check(cmd_ready_o == 1'b1, "R4 ready when idle", cmd_ready_o, 1);
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    check(busy_o && !cmd_ready_o, "R4 busy after accept", {busy_o, cmd_ready_o}, 2);
    while (!rsp_valid_o && guard < 5000) begin
      guard++;
      if (pu_load_i) pu_load_i = 1'b0;
      if (ackq) begin
        slot_ack_i = 1'b0; ackq = 0;
      end else if (slot_req_o) begin
        if (lat == 0) begin
          sent[idx] = slot_bit_o;
          slot_sample_i = slot_bit_o & dev[idx];
          slot_ack_i = 1'b1; ackq = 1;
          if (idx == BW - 1 && coin) begin
            pu_load_i = 1'b1; pu_ms_i = PW'(coin_v);
          end
          idx++;
          lat = $urandom % 3;
        end else lat--;
      end
      if (idx == BW && busy_o && !slot_req_o) hold_cnt++;
      if (spu_o) spu_cnt++;
      @(negedge clk_i);
    end
    pu_load_i = 1'b0;
    check(idx == BW, {req, " slot count"}, idx, BW);
    check(sent == e_sent, op[0] ? "R2 read slots all ones" : "R1 LSB-first data slots", sent, e_sent);
    check(rsp_data_o == (e_sent & dev),
          op[0] ? "R2 read result" : "R3 assembled result", rsp_data_o, e_sent & dev);
    check(hold_cnt == e_hold, {req, " busy after last slot"}, hold_cnt, e_hold);
    check(spu_cnt == e_spu, {req, " strong pullup cycles"}, spu_cnt, e_spu);
    @(negedge clk_i);
    check(!rsp_valid_o && !busy_o, "R4 single rsp pulse then idle", {rsp_valid_o, busy_o}, 0);
    if (op == 2'b00 && pend != 0) pend = 0;
    if (coin) pend = coin_v;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5e_a7c3));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(cmd_ready_o && !busy_o && !spu_o && !slot_req_o && !rsp_valid_o, "R4 reset state",
          {cmd_ready_o, busy_o, spu_o, slot_req_o, rsp_valid_o}, 5'b10000);

    run_cmd(2'b01, 8'h00, 8'hA5, 1'b1, 0, 0, "R2");
    run_cmd(2'b00, 8'h3C, 8'hFF, 1'b1, 0, 0, "R1 no request R7");
    load_pu(3);
    run_cmd(2'b01, 8'h00, 8'h5A, 1'b1, 0, 0, "R10 read ignores request");
    run_cmd(2'b00, 8'h81, 8'hFF, 1'b1, 0, 0, "R5 write pullup");
    run_cmd(2'b00, 8'h7E, 8'hFF, 1'b1, 0, 0, "R8 request cleared");
    load_pu(2);
    run_cmd(2'b00, 8'hC3, 8'hF0, 1'b0, 0, 0, "R6 wait without hw");
    load_pu(2);
    run_cmd(2'b10, 8'hF0, 8'h96, 1'b1, 0, 0, "R9 touch pullup");
    run_cmd(2'b10, 8'h0F, 8'h69, 1'b1, 0, 0, "R9 touch keeps request");
    load_pu(0);
    run_cmd(2'b00, 8'h55, 8'hFF, 1'b1, 0, 0, "R7 zero cancels");
    load_pu(4);
    run_cmd(2'b00, 8'hAA, 8'hFF, 1'b1, 1, 1, "R11 old duration used");
    run_cmd(2'b00, 8'h01, 8'hFF, 1'b1, 0, 0, "R11 new duration kept");
    run_cmd(2'b11, 8'h00, 8'h3E, 1'b0, 0, 0, "R2 op 11 reads");

    for (int n = 0; n < 60; n++) begin
      logic [1:0] op;
      if ($urandom % 3 == 0) load_pu($urandom % 4);
      op = 2'($urandom);
      run_cmd(op, 8'($urandom), 8'($urandom), 1'($urandom), ($urandom % 8) == 0,
              1 + $urandom % 3, "R5 R6 R8 R9 R10 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule